// File: doc/BRIEF.md
# Pairwise-Sign Max Pooling Unit

This block returns the largest of a window of signed samples. Each step takes four operands into registers. It forms the six pairwise differences between them and keeps only the sign of each difference, as a 6-bit winner code. A decoder then reads that code to select the operand that beat all the others. No comparator tree is involved: the code alone decides which operand is forwarded.

A window of one to four samples needs one step. A larger window runs as a chain of steps. Each later step feeds the running maximum back into operand slot 0 and takes up to three new samples into slots 1 to 3. Any slot with no sample behind it is loaded with the most negative representable value, so that slot can never win.

A producer offers four samples and a window size through a valid/ready handshake. A one-cycle valid pulse marks the pooled result at the end of the window. Every step takes exactly two cycles. In the first cycle the operands are captured, and in the second the winner code is registered.

Top module: `sign_maxpool`

## Requirements
- R1: While reset is high and in the cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A beat is accepted on a clock edge where `in_valid` and `in_ready` are both 1. In the cycle after an acceptance, `in_ready` is 0 (the decide cycle). In the cycle after that, `in_ready` is 1 again.
- R3: For a window of n ≤ 4, the first beat is the only beat. Lane i sits at `in_data[i*DW +: DW]`, and the output is the largest of lanes 0..n-1.
- R4: Winner-code bit k is 1 when the k-th difference is non-negative. The differences, in order, are slot0−slot1, slot0−slot2, slot0−slot3, slot1−slot2, slot1−slot3 and slot2−slot3. Exactly one operand is selected as the winner, and on equal values the lower slot wins.
- R5: For a window of n > 4, the window takes 1 + ceil((n−4)/3) beats. The first beat carries samples in lanes 0..3. Each later beat carries its new samples in lanes 0..2, and lane 3 of a later beat is ignored. The output is the largest of all n samples.
- R6: Lanes beyond the samples still owed to the window are ignored. Their values never change the result.
- R7: `win_size` is sampled only on the first beat of a window, and changes on later beats have no effect. A value of 0 acts as 1, and a value above MAXWIN acts as MAXWIN.
- R8: `out_valid` is a single-cycle pulse. It appears in the cycle that follows the decide cycle of the final step, and never after an earlier step.
- R9: Differences are formed one bit wider than the samples. The result is correct even between the most positive and the most negative values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A beat of samples is offered |
| in_ready | output | 1 | The block can take a beat (capture cycle) |
| in_data | input | 4*DW | Four signed samples, lane i at bits i*DW +: DW |
| win_size | input | WINW | Window length n, sampled on a window's first beat |
| out_valid | output | 1 | Pooled result valid (one-cycle pulse) |
| out_data | output | DW | Signed maximum of the window |

## Verification
The bench builds the block with 3-bit samples and MAXWIN of 10. At that width, every one of the 4096 four-sample windows can be driven, which covers every sign pattern of the winner code and both extreme values. The bench also sweeps each window length from 1 to 10 under many sample patterns. Unused lanes and the ignored lane carry the largest value, and `win_size` changes on later beats, so any leak into the result shows at the output. Sizes 0 and 15 exercise the clamping.

// File: rtl/sign_maxpool_pkg.sv
package sign_maxpool_pkg;

    localparam int NSLOT = 4;
    localparam int NPAIR = 6;

    typedef logic [NPAIR-1:0] wcode_t;
    typedef logic [NSLOT-1:0] slot_vec_t;

    typedef enum logic {
        PH_CAPTURE = 1'b0,
        PH_DECIDE  = 1'b1
    } phase_e;

    typedef struct packed {
        logic      use_fb;
        slot_vec_t live;
        logic      last;
    } step_ctl_t;

    // Minuend slot of difference k
    function automatic int pair_a(input int k);
        case (k)
            0, 1, 2: return 0;
            3, 4:    return 1;
            default: return 2;
        endcase
    endfunction

    // Subtrahend slot of difference k
    function automatic int pair_b(input int k);
        case (k)
            0:       return 1;
            1:       return 2;
            3:       return 2;
            default: return 3;
        endcase
    endfunction

    // A slot wins when it is >= every later slot and > every earlier slot
    function automatic slot_vec_t code_to_winner(input wcode_t c);
        slot_vec_t r;
        r[0] =  c[0] &  c[1] &  c[2];
        r[1] = ~c[0] &  c[3] &  c[4];
        r[2] = ~c[1] & ~c[3] &  c[5];
        r[3] = ~c[2] & ~c[4] & ~c[5];
        return r;
    endfunction

endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
    import sign_maxpool_pkg::*;
#(
    parameter int MAXWIN = 16,
    parameter int WINW   = $clog2(MAXWIN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [WINW-1:0] win_size,
    output logic            in_ready,
    output logic            accept,
    output logic            decide,
    output step_ctl_t       ctl,
    output logic            out_valid
);

    localparam logic [WINW-1:0] WMAX      = WINW'(MAXWIN);
    localparam logic [WINW-1:0] ONE       = WINW'(1);
    localparam logic [WINW-1:0] FIRST_CAP = WINW'(NSLOT);
    localparam logic [WINW-1:0] NEXT_CAP  = WINW'(NSLOT - 1);

    phase_e          ph_q;
    logic            busy_q;
    logic            last_q;
    logic            ov_q;
    logic [WINW-1:0] rem_q;

    logic [WINW-1:0] n_sel;
    logic [WINW-1:0] avail;
    logic [WINW-1:0] cap;
    logic [WINW-1:0] take;
    logic [WINW-1:0] rem_nx;

    assign in_ready  = (ph_q == PH_CAPTURE);
    assign accept    = in_valid && in_ready;
    assign decide    = (ph_q == PH_DECIDE);
    assign out_valid = ov_q;

    always_comb begin
        if (win_size == '0)
            n_sel = ONE;
        else if (win_size > WMAX)
            n_sel = WMAX;
        else
            n_sel = win_size;

        avail  = busy_q ? rem_q : n_sel;
        cap    = busy_q ? NEXT_CAP : FIRST_CAP;
        take   = (avail < cap) ? avail : cap;
        rem_nx = avail - take;

        ctl.use_fb = busy_q;
        ctl.last   = (rem_nx == '0);
        for (int s = 0; s < NSLOT; s++) begin
            if (busy_q)
                ctl.live[s] = (s == 0) ? 1'b1 : (WINW'(s - 1) < rem_q);
            else
                ctl.live[s] = (WINW'(s) < n_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_CAPTURE;
            busy_q <= 1'b0;
            last_q <= 1'b0;
            ov_q   <= 1'b0;
            rem_q  <= '0;
        end else begin
            ov_q <= 1'b0;
            case (ph_q)
                PH_CAPTURE: begin
                    if (accept) begin
                        ph_q   <= PH_DECIDE;
                        busy_q <= ~ctl.last;
                        rem_q  <= rem_nx;
                        last_q <= ctl.last;
                    end
                end
                default: begin
                    ph_q <= PH_CAPTURE;
                    ov_q <= last_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/sp_capture.sv
module sp_capture
    import sign_maxpool_pkg::*;
#(
    parameter int DW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  step_ctl_t           ctl,
    input  logic [NSLOT*DW-1:0] lanes,
    input  logic [DW-1:0]       fb,
    output logic [NSLOT*DW-1:0] opnd
);

    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic [DW-1:0] src;
        logic [DW-1:0] val;
        logic [DW-1:0] q;

        if (s == 0) begin : g_head
            assign src = ctl.use_fb ? fb : lanes[0 +: DW];
        end else begin : g_tail
            assign src = ctl.use_fb ? lanes[(s-1)*DW +: DW] : lanes[s*DW +: DW];
        end

        assign val = ctl.live[s] ? src : MINV;

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (load)
                q <= val;
        end

        assign opnd[s*DW +: DW] = q;
    end

endmodule

// File: rtl/sp_signcode.sv
module sp_signcode
    import sign_maxpool_pkg::*;
#(
    parameter int DW = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [NSLOT*DW-1:0] opnd,
    output wcode_t              code
);

    wcode_t nonneg;
    wcode_t code_q;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        localparam int IA = pair_a(k);
        localparam int IB = pair_b(k);
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW:0]   diff;

        assign a         = opnd[IA*DW +: DW];
        assign b         = opnd[IB*DW +: DW];
        assign diff      = {a[DW-1], a} - {b[DW-1], b};
        assign nonneg[k] = ~diff[DW];
    end

    always_ff @(posedge clk) begin
        if (rst)
            code_q <= '0;
        else if (load)
            code_q <= nonneg;
    end

    assign code = code_q;

endmodule

// File: rtl/sp_select.sv
module sp_select
    import sign_maxpool_pkg::*;
#(
    parameter int DW = 6
) (
    input  wcode_t              code,
    input  logic [NSLOT*DW-1:0] opnd,
    output slot_vec_t           winner,
    output logic [DW-1:0]       max_val
);

    always_comb begin
        winner  = code_to_winner(code);
        max_val = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (winner[s])
                max_val = max_val | opnd[s*DW +: DW];
        end
    end

endmodule

// File: rtl/sign_maxpool.sv
module sign_maxpool
    import sign_maxpool_pkg::*;
#(
    parameter int DW     = 6,
    parameter int MAXWIN = 16,
    parameter int WINW   = $clog2(MAXWIN + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [NSLOT*DW-1:0] in_data,
    input  logic [WINW-1:0]     win_size,
    output logic                out_valid,
    output logic [DW-1:0]       out_data
);

    logic                accept;
    logic                decide;
    step_ctl_t           ctl;
    logic [NSLOT*DW-1:0] opnd;
    wcode_t              code;
    slot_vec_t           win_sel;
    logic [DW-1:0]       max_val;

    sp_ctrl #(.MAXWIN(MAXWIN), .WINW(WINW)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .win_size  (win_size),
        .in_ready  (in_ready),
        .accept    (accept),
        .decide    (decide),
        .ctl       (ctl),
        .out_valid (out_valid)
    );

    sp_capture #(.DW(DW)) cap_i (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .ctl   (ctl),
        .lanes (in_data),
        .fb    (max_val),
        .opnd  (opnd)
    );

    sp_signcode #(.DW(DW)) code_i (
        .clk  (clk),
        .rst  (rst),
        .load (decide),
        .opnd (opnd),
        .code (code)
    );

    sp_select #(.DW(DW)) sel_i (
        .code    (code),
        .opnd    (opnd),
        .winner  (win_sel),
        .max_val (max_val)
    );

    assign out_data = max_val;

endmodule

// File: rtl/sign_maxpool_chk.sv
module sign_maxpool_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic [3:0] win_sel
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (in_ready && !out_valid));

    // R2
    accept_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R2
    ready_returns_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> in_ready);

    // R8
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R8
    after_decide_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(!in_ready));

    // R4
    winner_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot(win_sel));

endmodule

bind sign_maxpool sign_maxpool_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .win_sel   (win_sel)
);

// File: tb/sign_maxpool_tb_top.sv
`timescale 1ns/1ps
module sign_maxpool_tb_top;

    localparam int DW     = 3;
    localparam int MAXWIN = 10;
    localparam int WINW   = $clog2(MAXWIN + 1);
    localparam int VMIN   = -(1 << (DW - 1));
    localparam int VMAX   = (1 << (DW - 1)) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic [4*DW-1:0] in_data = '0;
    logic [WINW-1:0] win_size = '0;
    logic            out_valid;
    logic [DW-1:0]   out_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int samp [0:15];

    always #4 clk = ~clk;

    sign_maxpool #(.DW(DW), .MAXWIN(MAXWIN)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .win_size  (win_size),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one window. n_req is driven on win_size; n_eff is the length it must act as.
    task automatic run_window(input int n_req, input int n_eff, input string req);
        int exp_max = VMIN;
        int idx = 0;
        bit first = 1'b1;
        for (int i = 0; i < n_eff; i++)
            if (samp[i] > exp_max) exp_max = samp[i];
        while (idx < n_eff) begin
            int room = first ? 4 : 3;
            bit last;
            check(in_ready == 1'b1, "R2 ready before beat", int'(in_ready), 1);
            for (int l = 0; l < 4; l++) begin
                int v = VMAX;                   // unused/ignored lanes hold the largest value (R6)
                if (l < room && idx + l < n_eff) v = samp[idx + l];
                in_data[l*DW +: DW] = DW'(v);
            end
            win_size = first ? WINW'(n_req) : WINW'((n_req + 3) % 16); // R7 later beats
            idx  = idx + room;
            last = (idx >= n_eff);
            in_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check(in_ready == 1'b0, "R2 decide cycle", int'(in_ready), 0);
            check(out_valid == 1'b0, "R8 no early valid", int'(out_valid), 0);
            @(posedge clk);
            @(negedge clk);
            if (last) begin
                check(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
                check(int'($signed(out_data)) == exp_max, {req, " max"}, int'($signed(out_data)), exp_max);
            end else begin
                check(out_valid == 1'b0, "R8 mid-window valid", int'(out_valid), 0);
            end
            first = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 pulse length", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready == 1'b1, "R1 ready in reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);

        // R3 R4 R9: every 4-sample window at this width
        for (int c = 0; c < 4096; c++) begin
            for (int i = 0; i < 4; i++)
                samp[i] = ((c >> (3*i)) & 7) + VMIN;
            run_window(4, 4, "R3 R4 R9 exhaustive");
        end

        // R3 R5 R6 R7: every length with varied patterns
        for (int n = 1; n <= MAXWIN; n++) begin
            for (int p = 0; p < 64; p++) begin
                for (int i = 0; i < 16; i++)
                    samp[i] = ((i*5 + p*3 + (p >> 2)*i + (p >> 4)*i*i) % 8) + VMIN;
                if (n > 4) run_window(n, n, "R5 R6 R7 chained");
                else       run_window(n, n, "R3 R6 short");
            end
        end

        // R5: maximum in the ignored lane position of each later beat, elsewhere
        for (int pos = 0; pos < MAXWIN; pos++) begin
            for (int i = 0; i < 16; i++) samp[i] = VMIN + (i % 3);
            samp[pos] = VMAX;
            run_window(MAXWIN, MAXWIN, "R5 max position");
        end

        // R7: clamping of out-of-range sizes
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 16; i++) samp[i] = ((i + p) % 8) + VMIN;
            run_window(0, 1, "R7 size zero");
            run_window(15, MAXWIN, "R7 size above max");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule